// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small programmable logic device. It gathers the product terms that an AND array produces for it and ORs them into one sum. These are its own native terms plus any terms it borrows from neighbouring cells, each borrowed term enabled by its own configuration bit. A polarity bit can complement the sum. The result either goes straight to the pin or passes through a storage element that configuration turns into a D, T, JK or SR flip-flop. For the JK and SR types, a second, separate sum of product terms supplies the K or R input.

The storage element updates on a rising edge of a selectable macrocell clock: either a dedicated external clock pin or a product term. Both sources are sampled by the system clock, and each rising edge becomes a one-cycle update strobe. Preset and clear are level-driven product terms that act whether or not a macrocell clock edge arrives. The clear may be the OR of two terms. A host can overwrite the register from one bit of an 8-bit data bus, and can read it back on that same bit. The selected pin value is also returned to the AND array as feedback.

Top module: `pldmc_top`

## Requirements
- R1: With the register bypassed and polarity off, `pin_out` is the OR of all `pt_native` bits and of each `pt_borrow` bit whose `borrow_en` bit is 1. A borrowed term whose enable bit is 0 has no effect.
- R2: With `cfg_invert` = 1 the OR sum is complemented, both at the bypass path and at the flip-flop's D/T/J/S input.
- R3: With `cfg_registered` = 1, `pin_out` shows the stored bit with no further inversion. `fb_out` always equals `pin_out`.
- R4: The stored bit changes through its type logic only at a system clock edge where the selected source is sampled high after being sampled low. `cfg_clk_sel` = 0 selects `ext_clk` and 1 selects `pt_clk`; the other source is ignored. After reset a source already high gives no edge until it has been seen low.
- R5: Type code 0 (D): at an update the stored bit takes the polarised sum.
- R6: Type code 1 (T): at an update the stored bit inverts when the polarised sum is 1 and holds otherwise.
- R7: Type code 2 (JK): J is the polarised sum and K is the OR of `pt_second`. J alone sets, K alone clears, both toggle, neither holds.
- R8: Type code 3 (SR): S is the polarised sum and R is the OR of `pt_second`. S alone sets, R alone clears, both or neither hold.
- R9: `pt_preset` = 1 makes the stored bit 1 at the next system clock edge, with no macrocell clock edge needed.
- R10: Clear is the OR of the `pt_clear` bits. It makes the stored bit 0 at the next system clock edge and wins over preset.
- R11: `host_load` = 1 writes `host_data[CELL_IDX]` into the stored bit at the next system clock edge. It wins over a macrocell update in the same cycle and loses to preset and clear.
- R12: One cycle after `host_rd` = 1, `host_rd_data[CELL_IDX]` holds the stored bit as it was before that edge, never complemented, and every other bit is 0. After a cycle without `host_rd`, the whole bus is 0.
- R13: A synchronous `rst` clears the stored bit and the read bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_native | input | NATIVE_PT | Native product terms |
| pt_borrow | input | BORROW_PT | Terms offered by neighbouring cells |
| borrow_en | input | BORROW_PT | Per-term borrow enable |
| pt_second | input | SECOND_PT | Terms of the K/R sum |
| pt_clk | input | 1 | Product-term macrocell clock |
| ext_clk | input | 1 | Dedicated external macrocell clock |
| pt_preset | input | 1 | Preset term, active high |
| pt_clear | input | CLEAR_PT | Clear terms, ORed, active high |
| cfg_invert | input | 1 | Polarity complement |
| cfg_registered | input | 1 | 1 selects the stored bit for the pin |
| cfg_ff_kind | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| cfg_clk_sel | input | 1 | 0 external clock, 1 product-term clock |
| host_load | input | 1 | Host write strobe |
| host_data | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read request |
| host_rd_data | output | DATA_W | Registered read data |
| pin_out | output | 1 | Pin value |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
The bench builds the cell with three native terms and six borrow slots, the narrower group's sizing. The borrow enables can then mask terms at both ends of a wide vector. It places the cell on data bit 5, so a wrong index or a leak onto neighbouring read bits shows up where bit 0 would hide it. Two K/R terms and two clear terms let each clear term and the JK/SR both-asserted cases be exercised separately.

// File: rtl/pldmc_pkg.sv
package pldmc_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;
endpackage

// File: rtl/pldmc_sum.sv
module pldmc_sum #(
  parameter int NATIVE_PT = 4,
  parameter int BORROW_PT = 6
) (
  input  logic [NATIVE_PT-1:0] pt_native,
  input  logic [BORROW_PT-1:0] pt_borrow,
  input  logic [BORROW_PT-1:0] borrow_en,
  input  logic                 invert,
  output logic                 sum_pol
);
  logic [BORROW_PT-1:0] gated;

  // Each borrow slot passes only when the neighbour hands it over.
  for (genvar g = 0; g < BORROW_PT; g++) begin : g_borrow
    assign gated[g] = pt_borrow[g] & borrow_en[g];
  end

  assign sum_pol = (|pt_native | |gated) ^ invert;
endmodule

// File: rtl/pldmc_clk_edge.sv
module pldmc_clk_edge (
  input  logic clk,
  input  logic rst,
  input  logic ext_clk,
  input  logic pt_clk,
  input  logic sel,
  output logic tick
);
  logic src, src_q;

  assign src = sel ? pt_clk : ext_clk;

  // Reset value 1: a source already high at reset is not an edge.
  always_ff @(posedge clk) begin
    if (rst) src_q <= 1'b1;
    else     src_q <= src;
  end

  assign tick = src & ~src_q;

  p_tick_once_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pldmc_reg.sv
module pldmc_reg
  import pldmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ff_kind_e kind,
  input  logic     d,
  input  logic     k,
  input  logic     tick,
  input  logic     pre,
  input  logic     clr,
  input  logic     ld,
  input  logic     ld_bit,
  output logic     q
);
  logic nxt;

  always_comb begin
    nxt = q;
    unique case (kind)
      FF_D:  nxt = d;
      FF_T:  nxt = q ^ d;
      FF_JK: begin
        case ({d, k})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~q;
          default: nxt = q;
        endcase
      end
      FF_SR: begin
        case ({d, k})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = q;
        endcase
      end
      default: nxt = q;
    endcase
  end

  // Priority: clear, preset, host load, clocked update.
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (clr)  q <= 1'b0;
    else if (pre)  q <= 1'b1;
    else if (ld)   q <= ld_bit;
    else if (tick) q <= nxt;
  end

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
  p_preset_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (pre && !clr) |=> q);
  p_load_takes_r11: assert property (@(posedge clk) disable iff (rst)
    (ld && !pre && !clr) |=> (q == $past(ld_bit)));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld && !pre && !clr) |=> $stable(q));
  p_sr_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == FF_SR && d && k && !ld && !pre && !clr) |=> $stable(q));
  p_jk_both_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && kind == FF_JK && d && k && !ld && !pre && !clr) |=> (q != $past(q)));
endmodule

// File: rtl/pldmc_top.sv
module pldmc_top
  import pldmc_pkg::*;
#(
  parameter int NATIVE_PT = 4,
  parameter int BORROW_PT = 6,
  parameter int SECOND_PT = 2,
  parameter int CLEAR_PT  = 2,
  parameter int DATA_W    = 8,
  parameter int CELL_IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NATIVE_PT-1:0] pt_native,
  input  logic [BORROW_PT-1:0] pt_borrow,
  input  logic [BORROW_PT-1:0] borrow_en,
  input  logic [SECOND_PT-1:0] pt_second,
  input  logic                 pt_clk,
  input  logic                 ext_clk,
  input  logic                 pt_preset,
  input  logic [CLEAR_PT-1:0]  pt_clear,
  input  logic                 cfg_invert,
  input  logic                 cfg_registered,
  input  logic [1:0]           cfg_ff_kind,
  input  logic                 cfg_clk_sel,
  input  logic                 host_load,
  input  logic [DATA_W-1:0]    host_data,
  input  logic                 host_rd,
  output logic [DATA_W-1:0]    host_rd_data,
  output logic                 pin_out,
  output logic                 fb_out
);
  localparam logic [DATA_W-1:0] CELL_MASK = DATA_W'(1) << CELL_IDX;

  logic sum_pol, tick, q;

  pldmc_sum #(.NATIVE_PT(NATIVE_PT), .BORROW_PT(BORROW_PT)) u_sum (
    .pt_native (pt_native),
    .pt_borrow (pt_borrow),
    .borrow_en (borrow_en),
    .invert    (cfg_invert),
    .sum_pol   (sum_pol)
  );

  pldmc_clk_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .ext_clk (ext_clk),
    .pt_clk  (pt_clk),
    .sel     (cfg_clk_sel),
    .tick    (tick)
  );

  pldmc_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .kind   (ff_kind_e'(cfg_ff_kind)),
    .d      (sum_pol),
    .k      (|pt_second),
    .tick   (tick),
    .pre    (pt_preset),
    .clr    (|pt_clear),
    .ld     (host_load),
    .ld_bit (host_data[CELL_IDX]),
    .q      (q)
  );

  assign pin_out = cfg_registered ? q : sum_pol;
  assign fb_out  = pin_out;

  always_ff @(posedge clk) begin
    if (rst)          host_rd_data <= '0;
    else if (host_rd) host_rd_data <= q ? CELL_MASK : '0;
    else              host_rd_data <= '0;
  end

  p_rd_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (host_rd_data == '0));
  p_rd_lane_r12: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> (host_rd_data[CELL_IDX] == $past(q)));
  p_rd_others_r12: assert property (@(posedge clk) disable iff (rst)
    (host_rd_data & ~CELL_MASK) == '0);
endmodule

// File: tb/pldmc_top_tb_top.sv
`timescale 1ns/1ps
module pldmc_top_tb_top;
  localparam int NAT  = 3;
  localparam int BOR  = 6;
  localparam int SEC  = 2;
  localparam int CLRN = 2;
  localparam int DW   = 8;
  localparam int CELL = 5;

  logic clk = 1'b0;
  logic rst;
  logic [NAT-1:0]  pt_native;
  logic [BOR-1:0]  pt_borrow, borrow_en;
  logic [SEC-1:0]  pt_second;
  logic            pt_clk, ext_clk, pt_preset;
  logic [CLRN-1:0] pt_clear;
  logic            cfg_invert, cfg_registered, cfg_clk_sel;
  logic [1:0]      cfg_ff_kind;
  logic            host_load, host_rd;
  logic [DW-1:0]   host_data, host_rd_data;
  logic            pin_out, fb_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pldmc_top #(.NATIVE_PT(NAT), .BORROW_PT(BOR), .SECOND_PT(SEC),
              .CLEAR_PT(CLRN), .DATA_W(DW), .CELL_IDX(CELL)) dut_i (
    .clk(clk), .rst(rst), .pt_native(pt_native), .pt_borrow(pt_borrow),
    .borrow_en(borrow_en), .pt_second(pt_second), .pt_clk(pt_clk),
    .ext_clk(ext_clk), .pt_preset(pt_preset), .pt_clear(pt_clear),
    .cfg_invert(cfg_invert), .cfg_registered(cfg_registered),
    .cfg_ff_kind(cfg_ff_kind), .cfg_clk_sel(cfg_clk_sel),
    .host_load(host_load), .host_data(host_data), .host_rd(host_rd),
    .host_rd_data(host_rd_data), .pin_out(pin_out), .fb_out(fb_out)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic pulse_ext();
    ext_clk = 1'b1; @(negedge clk);
    ext_clk = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_pt();
    pt_clk = 1'b1; @(negedge clk);
    pt_clk = 1'b0; @(negedge clk);
  endtask

  // Read the stored bit through the host port (R12 path).
  task automatic rd(output logic v);
    host_rd = 1'b1; @(negedge clk);
    host_rd = 1'b0;
    v = host_rd_data[CELL];
    chk(|(host_rd_data & ~(DW'(1) << CELL)), 1'b0, "R12", "other read bits");
  endtask

  task automatic force_q(input logic v);
    if (v) pt_preset = 1'b1; else pt_clear[0] = 1'b1;
    @(negedge clk);
    pt_preset = 1'b0; pt_clear = '0;
  endtask

  task automatic t_reset();
    logic v;
    chk(pin_out, 1'b0, "R13", "pin after reset");
    chk(|host_rd_data, 1'b0, "R13", "read bus after reset");
    rd(v); chk(v, 1'b0, "R13", "stored bit after reset");
    repeat (2) @(negedge clk);
    rd(v); chk(v, 1'b0, "R4", "source high through reset is no edge");
    ext_clk = 1'b0; @(negedge clk);
    pulse_ext();
    rd(v); chk(v, 1'b1, "R4", "first real edge after reset");
  endtask

  task automatic t_sum();
    cfg_registered = 1'b0; pt_native = '0; pt_borrow = '0; borrow_en = '0;
    #1 chk(pin_out, 1'b0, "R1", "all terms low");
    pt_native = 3'b100;
    #1 chk(pin_out, 1'b1, "R1", "top native term");
    pt_native = '0; pt_borrow = 6'b001000;
    #1 chk(pin_out, 1'b0, "R1", "unenabled borrow ignored");
    borrow_en = 6'b001000;
    #1 chk(pin_out, 1'b1, "R1", "enabled borrow");
    pt_borrow = 6'b100000; borrow_en = 6'b100000;
    #1 chk(pin_out, 1'b1, "R1", "last borrow slot");
    cfg_invert = 1'b1;
    #1 chk(pin_out, 1'b0, "R2", "inverted true sum");
    pt_borrow = '0;
    #1 chk(pin_out, 1'b1, "R2", "inverted false sum");
    chk(fb_out, pin_out, "R3", "feedback equals pin");
    cfg_invert = 1'b0; borrow_en = '0;
    @(negedge clk);
  endtask

  task automatic t_dmode();
    cfg_registered = 1'b1; cfg_ff_kind = 2'd0; cfg_clk_sel = 1'b0;
    force_q(1'b1);
    pt_native = '0; pulse_ext();
    chk(pin_out, 1'b0, "R5", "D loads 0");
    pt_native = 3'b001; pulse_pt();
    chk(pin_out, 1'b0, "R4", "unselected source ignored");
    repeat (3) @(negedge clk);
    chk(pin_out, 1'b0, "R4", "no edge no change");
    cfg_clk_sel = 1'b1; @(negedge clk); pulse_pt();
    chk(pin_out, 1'b1, "R5", "D loads 1 on term clock");
    pt_native = '0; cfg_invert = 1'b1; pulse_pt();
    chk(pin_out, 1'b1, "R2", "complemented zero stores 1");
    cfg_invert = 1'b0; pulse_pt();
    chk(pin_out, 1'b0, "R5", "D loads 0 again");
    chk(fb_out, 1'b0, "R3", "feedback follows register");
    cfg_clk_sel = 1'b0; @(negedge clk);
  endtask

  task automatic t_tmode();
    cfg_ff_kind = 2'd1; force_q(1'b0);
    pt_native = 3'b010; pulse_ext();
    chk(pin_out, 1'b1, "R6", "toggle up");
    pulse_ext();
    chk(pin_out, 1'b0, "R6", "toggle down");
    pt_native = '0; pulse_ext();
    chk(pin_out, 1'b0, "R6", "T hold");
  endtask

  task automatic t_jk();
    cfg_ff_kind = 2'd2; force_q(1'b0);
    pt_native = 3'b001; pt_second = '0; pulse_ext();
    chk(pin_out, 1'b1, "R7", "J sets");
    pt_native = '0; pt_second = 2'b01; pulse_ext();
    chk(pin_out, 1'b0, "R7", "K clears");
    pt_native = 3'b001; pt_second = 2'b10; pulse_ext();
    chk(pin_out, 1'b1, "R7", "JK toggle up");
    pulse_ext();
    chk(pin_out, 1'b0, "R7", "JK toggle down");
    pt_native = '0; pt_second = '0; pulse_ext();
    chk(pin_out, 1'b0, "R7", "JK hold");
  endtask

  task automatic t_sr();
    cfg_ff_kind = 2'd3; force_q(1'b0);
    pt_native = 3'b001; pt_second = '0; pulse_ext();
    chk(pin_out, 1'b1, "R8", "S sets");
    pt_second = 2'b11; pulse_ext();
    chk(pin_out, 1'b1, "R8", "S and R hold high");
    pt_native = '0; pt_second = 2'b01; pulse_ext();
    chk(pin_out, 1'b0, "R8", "R clears");
    pt_native = 3'b001; pulse_ext();
    chk(pin_out, 1'b0, "R8", "S and R hold low");
    pt_native = '0; pt_second = '0;
  endtask

  task automatic t_preclr();
    cfg_ff_kind = 2'd0;
    pt_preset = 1'b1; @(negedge clk); pt_preset = 1'b0;
    chk(pin_out, 1'b1, "R9", "preset without clock");
    pt_clear = 2'b10; @(negedge clk); pt_clear = '0;
    chk(pin_out, 1'b0, "R10", "second clear term");
    pt_preset = 1'b1; @(negedge clk);
    pt_clear = 2'b01; @(negedge clk);
    chk(pin_out, 1'b0, "R10", "clear beats preset");
    pt_preset = 1'b0; pt_clear = '0; @(negedge clk);
    chk(pin_out, 1'b0, "R10", "stays clear after release");
  endtask

  task automatic t_load();
    cfg_ff_kind = 2'd0; pt_native = '0;
    host_data = 8'h20; host_load = 1'b1; @(negedge clk); host_load = 1'b0;
    chk(pin_out, 1'b1, "R11", "load bit 5 set");
    host_data = 8'hDF; host_load = 1'b1; @(negedge clk); host_load = 1'b0;
    chk(pin_out, 1'b0, "R11", "load bit 5 clear, others ignored");
    pt_native = 3'b001; host_data = 8'h00;
    host_load = 1'b1; ext_clk = 1'b1; @(negedge clk);
    host_load = 1'b0; ext_clk = 1'b0; @(negedge clk);
    chk(pin_out, 1'b0, "R11", "load beats clock edge");
    pt_native = '0;
    host_load = 1'b1; pt_preset = 1'b1; @(negedge clk);
    host_load = 1'b0; pt_preset = 1'b0;
    chk(pin_out, 1'b1, "R11", "preset beats load");
  endtask

  task automatic t_read();
    logic v;
    cfg_invert = 1'b1;
    #1 chk(pin_out, 1'b1, "R3", "register not re-inverted at pin");
    rd(v); chk(v, 1'b1, "R12", "read raw stored bit");
    @(negedge clk);
    chk(|host_rd_data, 1'b0, "R12", "bus zero after idle cycle");
    host_rd = 1'b1; pt_clear = 2'b01; @(negedge clk);
    host_rd = 1'b0; pt_clear = '0;
    chk(host_rd_data[CELL], 1'b1, "R12", "read shows pre-edge value");
    rd(v); chk(v, 1'b0, "R12", "read after clear");
    cfg_invert = 1'b0;
  endtask

  initial begin
    rst = 1'b1; pt_native = 3'b001; pt_borrow = '0; borrow_en = '0;
    pt_second = '0; pt_clk = 1'b0; ext_clk = 1'b1; pt_preset = 1'b0;
    pt_clear = '0; cfg_invert = 1'b0; cfg_registered = 1'b1;
    cfg_ff_kind = 2'd0; cfg_clk_sel = 1'b0; host_load = 1'b0;
    host_data = '0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sum();
    t_dmode();
    t_tmode();
    t_jk();
    t_sr();
    t_preclr();
    t_load();
    t_read();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule